// File: doc/BRIEF.md
# Shadow-Updated Multi-Compare Pulse-Width Modulator

This block generates up to six pulse-width modulated waveforms from one counter. The counter is compared each cycle against a bank of seven compare values. Compare value 0 fixes the period. The counter climbs from 0 and returns to 0 on the cycle after it equals compare 0. Each output has its own mode. In single-edge mode it rises at the start of a period and falls at its own compare. In double-edge mode two neighbouring compares place its rising and falling edges anywhere in the period.

Software writes new compare values into shadow storage through a plain register-write port. A shadow value stays out of use until a release bit for that compare is set. Even then it moves into the active set only at the next period boundary. Because of this, a waveform never receives a half-updated pair of edges. A sticky flag per compare records equality, and a write-one clear input resets it.

Output index i (bit i of `pwm_out` and of `dbl_mode`, i = 0..5) is channel i+1. In single-edge mode it uses compare i+1. In double-edge mode compare i sets it and compare i+1 clears it. Bit k of `latch_set`, `latch_pend`, `match_flag` and `flag_clr` refers to compare k. Writes have no back-pressure: a write strobed on any clock edge always lands. Every port is a plain control or status pin.

Top module: `mpwm_core`

## Requirements
- R1: The counter runs 0, 1, ... up to compare 0. On the cycle after it equals compare 0 it is 0 again, so one period lasts compare0+1 cycles.
- R2: A `wr_en` cycle stores `wr_data` in the shadow slot selected by `wr_addr`. While that compare's release bit is unset, the write has no effect on any output.
- R3: In single-edge mode (`dbl_mode[i]`=0), output i is driven high on the cycle after count 0. It is driven low on the cycle after the count equals compare i+1, so it is high for compare i+1 cycles each period. Compare 0 holds the output low. A compare larger than the period holds the output high.
- R4: In double-edge mode (`dbl_mode[i]`=1), output i is set on the cycle after the count equals compare i and cleared on the cycle after it equals compare i+1. When set < clear, the result is a positive-going pulse clear-set cycles wide. When set > clear, the result is a negative-going pulse: the output is low for set-clear cycles.
- R5: When the set and clear events of an output fall on the same count, the clear wins.
- R6: Active compare values change only on the edge that ends a cycle in which the counter equals compare 0. A released value therefore governs the whole next period and never part of the current one.
- R7: A 1 on `latch_set[k]` marks compare k as pending (visible on `latch_pend[k]` the next cycle). The pending bit stays set until the next period boundary copies shadow k into the active set, and then it clears itself.
- R8: `match_flag[k]` becomes 1 on the cycle after the count equals compare k and stays 1 until a 1 on `flag_clr[k]` clears it. If a set and a clear happen together, the set wins.
- R9: After reset, all outputs, flags and pending bits are 0, and every shadow and active compare is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_addr | input | IDX_W | Compare slot to write |
| wr_data | input | CNT_W | Shadow value |
| latch_set | input | NUM_MATCH | Release request per compare |
| latch_pend | output | NUM_MATCH | Release pending per compare |
| dbl_mode | input | NUM_OUT | 1 = double-edge mode per output |
| flag_clr | input | NUM_MATCH | Write-one clear of match flags |
| match_flag | output | NUM_MATCH | Sticky equality flag per compare |
| pwm_out | output | NUM_OUT | PWM waveforms |

## Verification
The bench builds the block with a CNT_W of 8 bits, the default seven compares and six outputs, and a period of ten cycles. This short period lets one measurement window cover a full period. It also lets a compare of 12 lie beyond the period, which exercises the constant-high case. Duty is measured as a count of high cycles over one period, so the result does not depend on phase. The bench syncs on an output's rising edge so that it knows the counter phase. This lets it release a value in mid-period and observe the pending bit both before and after the boundary.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_t;
endpackage

// File: rtl/mpwm_match_bank.sv
module mpwm_match_bank #(
  parameter int NUM_MATCH = 7,
  parameter int CNT_W     = 32,
  parameter int IDX_W     = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_addr,
  input  logic [CNT_W-1:0]                 wr_data,
  input  logic [NUM_MATCH-1:0]             latch_set,
  input  logic                             boundary,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]  act_o,
  output logic [NUM_MATCH-1:0]             pend_o
);
  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_q;
  logic [NUM_MATCH-1:0]            pend_q;
  logic [NUM_MATCH-1:0]            xfer;

  assign xfer = boundary ? pend_q : '0;

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[k] <= '0;
      end else if (wr_en && (wr_addr == IDX_W'(k))) begin
        shadow_q[k] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[k] <= '0;
      end else if (xfer[k]) begin
        act_q[k] <= shadow_q[k];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
      end else begin
        pend_q[k] <= (pend_q[k] & ~xfer[k]) | latch_set[k];
      end
    end
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/mpwm_out_cell.sv
module mpwm_out_cell
  import mpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic at_start,
  input  logic set_hit,
  input  logic clr_hit,
  output logic pwm
);
  logic set_ev;
  logic pwm_q;

  assign set_ev = (edge_mode_t'(mode) == EDGE_DOUBLE) ? set_hit : at_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (clr_hit) begin
      pwm_q <= 1'b0;
    end else if (set_ev) begin
      pwm_q <= 1'b1;
    end
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/mpwm_core.sv
module mpwm_core #(
  parameter int NUM_MATCH = 7,
  parameter int NUM_OUT   = 6,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(NUM_MATCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [NUM_MATCH-1:0] latch_set,
  output logic [NUM_MATCH-1:0] latch_pend,
  input  logic [NUM_OUT-1:0]   dbl_mode,
  input  logic [NUM_MATCH-1:0] flag_clr,
  output logic [NUM_MATCH-1:0] match_flag,
  output logic [NUM_OUT-1:0]   pwm_out
);
  logic [CNT_W-1:0]                cnt_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act;
  logic [NUM_MATCH-1:0]            hit;
  logic [NUM_MATCH-1:0]            flag_q;
  logic                            boundary;
  logic                            at_start;

  mpwm_match_bank #(
    .NUM_MATCH(NUM_MATCH),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .latch_set(latch_set),
    .boundary (boundary),
    .act_o    (act),
    .pend_o   (latch_pend)
  );

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
    assign hit[k] = (cnt_q == act[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else if (hit[k]) begin
        flag_q[k] <= 1'b1;
      end else if (flag_clr[k]) begin
        flag_q[k] <= 1'b0;
      end
    end
  end

  assign boundary   = hit[0];
  assign at_start   = (cnt_q == '0);
  assign match_flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (boundary) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    mpwm_out_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (dbl_mode[g]),
      .at_start(at_start),
      .set_hit (hit[g]),
      .clr_hit (hit[g+1]),
      .pwm     (pwm_out[g])
    );
  end
endmodule

// File: rtl/mpwm_core_chk.sv
module mpwm_core_chk #(
  parameter int NUM_MATCH = 7,
  parameter int NUM_OUT   = 6,
  parameter int CNT_W     = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [CNT_W-1:0]                cnt_q,
  input logic [NUM_MATCH-1:0][CNT_W-1:0] act,
  input logic [NUM_MATCH-1:0]            latch_set,
  input logic [NUM_MATCH-1:0]            latch_pend,
  input logic [NUM_MATCH-1:0]            match_flag,
  input logic [NUM_OUT-1:0]              dbl_mode,
  input logic [NUM_OUT-1:0]              pwm_out
);
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == act[0]) |=> (cnt_q == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != act[0]) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R1
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != act[0]) |=> $stable(act)); // R6

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_k
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == act[0] && latch_pend[k] && !latch_set[k]) |=> !latch_pend[k]); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == act[k]) |=> match_flag[k]); // R8
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_o
    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_out[g]) && !$past(dbl_mode[g])) |-> ($past(cnt_q) == '0)); // R3
  end
endmodule

bind mpwm_core mpwm_core_chk #(
  .NUM_MATCH(NUM_MATCH),
  .NUM_OUT  (NUM_OUT),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_q     (cnt_q),
  .act       (act),
  .latch_set (latch_set),
  .latch_pend(latch_pend),
  .match_flag(match_flag),
  .dbl_mode  (dbl_mode),
  .pwm_out   (pwm_out)
);

// File: tb/mpwm_core_test.sv
module mpwm_core_test;
  localparam int NM = 7;
  localparam int NO = 6;
  localparam int CW = 8;
  localparam int AW = $clog2(NM);
  localparam int PER = 10;

  // {dbl, set(match1), clr(match2), expected high cycles per period}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'd0, 8'd3,  8'd3},
    {8'd0, 8'd0, 8'd7,  8'd7},
    {8'd0, 8'd0, 8'd0,  8'd0},
    {8'd0, 8'd0, 8'd12, 8'd10},
    {8'd1, 8'd2, 8'd6,  8'd4},
    {8'd1, 8'd6, 8'd2,  8'd6},
    {8'd1, 8'd4, 8'd4,  8'd0},
    {8'd1, 8'd0, 8'd9,  8'd9}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NM-1:0] latch_set = '0;
  logic [NM-1:0] latch_pend;
  logic [NO-1:0] dbl_mode = '0;
  logic [NM-1:0] flag_clr = '0;
  logic [NM-1:0] match_flag;
  logic [NO-1:0] pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mpwm_core #(.NUM_MATCH(NM), .NUM_OUT(NO), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .latch_set(latch_set), .latch_pend(latch_pend),
    .dbl_mode(dbl_mode), .flag_clr(flag_clr), .match_flag(match_flag),
    .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic release_bits(input logic [NM-1:0] m);
    latch_set = m;
    @(negedge clk);
    latch_set = '0;
  endtask

  task automatic measure(output int h);
    h = 0;
    repeat (PER) begin
      @(negedge clk);
      h += int'(pwm_out[1]);
    end
  endtask

  // Wait for output index 2 (single edge, compare 3) to rise: counter is then 1
  task automatic sync_start();
    logic prev;
    prev = pwm_out[2];
    forever begin
      @(negedge clk);
      if (!prev && pwm_out[2]) break;
      prev = pwm_out[2];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check("R9 pwm_out", int'(pwm_out), 0);
    check("R9 match_flag", int'(match_flag), 0);
    check("R9 latch_pend", int'(latch_pend), 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(0, PER - 1);
    wr(3, 5);
    release_bits(7'b0001001);
    repeat (3) @(negedge clk);

    // R3 R4 R5 table
    foreach (VEC[i]) begin
      dbl_mode[1] = VEC[i][24];
      wr(1, int'(VEC[i][23:16]));
      wr(2, int'(VEC[i][15:8]));
      release_bits(7'b0000110);
      repeat (25) @(negedge clk);
      measure(h);
      check(VEC[i][24] ? "R4/R5 double-edge duty" : "R3 single-edge duty",
            h, int'(VEC[i][7:0]));
    end

    // R2: shadow write without release is ignored
    dbl_mode[1] = 1'b0;
    wr(2, 3);
    release_bits(7'b0000100);
    repeat (25) @(negedge clk);
    wr(2, 8);
    repeat (25) @(negedge clk);
    measure(h);
    check("R2 unreleased shadow ignored", h, 3);
    check("R2 no pending without release", int'(latch_pend[2]), 0);

    // R6 R7: mid-period release waits for the boundary
    sync_start();
    release_bits(7'b0000100);
    check("R7 pending after release", int'(latch_pend[2]), 1);
    repeat (3) @(negedge clk);
    check("R6 pending held mid-period", int'(latch_pend[2]), 1);
    repeat (10) @(negedge clk);
    check("R7 pending self-clears", int'(latch_pend[2]), 0);
    repeat (5) @(negedge clk);
    measure(h);
    check("R6 released value in effect", h, 8);

    // R8: flag clear and re-set
    sync_start();
    flag_clr[0] = 1'b1;
    @(negedge clk);
    flag_clr[0] = 1'b0;
    check("R8 flag cleared", int'(match_flag[0]), 0);
    repeat (10) @(negedge clk);
    check("R8 flag set again", int'(match_flag[0]), 1);
    wr(5, 50);
    release_bits(7'b0100000);
    repeat (12) @(negedge clk);
    flag_clr[5] = 1'b1;
    @(negedge clk);
    flag_clr[5] = 1'b0;
    repeat (25) @(negedge clk);
    check("R8 unmatched flag stays clear", int'(match_flag[5]), 0);

    // R1: shorter period (5 cycles), compare 2 = 3 -> 6 high in 10 cycles
    wr(0, 4);
    wr(2, 3);
    release_bits(7'b0000101);
    repeat (25) @(negedge clk);
    measure(h);
    check("R1 period from compare 0", h, 6);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule